// File: doc/BRIEF.md
# Host I/O System Control Port

This block sits on the I/O space of an 8-bit host processor on a board with a second processor. Each I/O write is a command, and the port number alone selects the command; the data byte is never looked at. The commands hold the second processor in reset or release it, enable or disable the host's frame interrupt, and pick which half of a 32 KB paged ROM appears in the host's 16 KB window at 0x8000–0xBFFF.

An I/O read of port 0 returns a status byte taken from a short fixed cycle of values. The cycle moves forward once for each read access. Every other port reads as 0xFF.

The frame interrupt comes from a vertical-blank pulse input. It is latched into a pending flag, which drives the interrupt request until software or an acknowledge clears it. The ROM window decode is combinational, so the ROM sees its address in the same cycle as the host bus.

Top module: `sys_ctl_port`

## Requirements
- R1: An I/O write to port 0x00 sets `sub_rst` high on the clock edge that samples the start of the strobe, whatever the data byte is.
- R2: An I/O write to port 0x01 sets `sub_rst` low on the clock edge that samples the start of the strobe, whatever the data byte is.
- R3: An I/O write to port 0x06 clears the interrupt enable and any pending interrupt. An I/O write to port 0x07 sets the interrupt enable. Neither write changes the other outputs.
- R4: A `vblank` pulse that arrives while interrupts are enabled sets `irq_req` on the next edge. `irq_req` stays high until a write to port 0x06 or an `irq_ack` pulse clears it. If a clear and a pulse arrive in the same cycle, the clear wins. A pulse that arrives while interrupts are disabled has no effect.
- R5: An I/O write to port 0x08 selects bank 0. An I/O write to port 0x09 selects bank 1. `bank_sel` shows the selected bank.
- R6: `rom_cs` is high exactly when `host_addr` is in 0x8000–0xBFFF. `rom_addr` is {bank, host_addr[13:0]}. Both are combinational.
- R7: Reads of port 0x00 return 0xC7, then 0x55, then 0x00, and the cycle then repeats. `io_rdata` is loaded on the edge that samples the start of the read strobe and holds its value until the next read.
- R8: The status cycle moves forward by one for each read strobe of port 0x00, even when the strobe is held for several cycles. Reads of any other port return 0xFF and do not move the cycle forward.
- R9: Writes to ports 0x02–0x05 and 0x0A–0x0F change no output and do not move the status cycle.
- R10: Only bits 7:0 of `io_addr` are decoded, so port 0x0100 acts as port 0x00.
- R11: After reset, `sub_rst` is high, interrupts are disabled with nothing pending, bank 0 is selected, `io_rdata` is 0xFF and the next status read returns 0xC7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O strobe; a new access starts on its rising level |
| io_rd | input | 1 | 1 for a read access, 0 for a write access |
| io_addr | input | 16 | I/O address; only bits 7:0 are decoded |
| io_wdata | input | 8 | Write data; ignored |
| io_rdata | output | 8 | Registered read data |
| vblank | input | 1 | Vertical-blank pulse, one cycle wide |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| host_addr | input | 16 | Host memory address for the ROM window decode |
| sub_rst | output | 1 | Reset for the second processor, active high |
| irq_req | output | 1 | Interrupt request to the host |
| bank_sel | output | 1 | Selected ROM bank |
| rom_cs | output | 1 | ROM window select |
| rom_addr | output | 15 | Address into the 32 KB ROM |

## Verification
The assertions assume two things about the inputs. First, an access is marked by `io_req` going from low to high, and `io_rd` and `io_addr` stay stable while the strobe is high. Second, `vblank` and `irq_ack` are single-cycle pulses.

The bench drives every input on the falling clock edge. Each strobe is dropped for at least one cycle before the next access starts. The bench holds some read strobes for several cycles on purpose, so that the once-per-access rule on the status cycle is exercised.

// File: rtl/sys_ctl_port.sv
module sys_ctl_port #(
  parameter int IO_AW   = 16,
  parameter int HOST_AW = 16,
  parameter int DW      = 8,
  parameter int WIN_AW  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_req,
  input  logic               io_rd,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic [DW-1:0]      io_wdata,
  output logic [DW-1:0]      io_rdata,
  input  logic               vblank,
  input  logic               irq_ack,
  input  logic [HOST_AW-1:0] host_addr,
  output logic               sub_rst,
  output logic               irq_req,
  output logic               bank_sel,
  output logic               rom_cs,
  output logic [WIN_AW:0]    rom_addr
);
  localparam logic [7:0] P_RST_ON  = 8'h00;
  localparam logic [7:0] P_RST_OFF = 8'h01;
  localparam logic [7:0] P_IRQ_OFF = 8'h06;
  localparam logic [7:0] P_IRQ_ON  = 8'h07;
  localparam logic [7:0] P_BANK0   = 8'h08;
  localparam logic [7:0] P_BANK1   = 8'h09;
  localparam logic [7:0] P_STATUS  = 8'h00;
  localparam int         WIN_TAG_W = HOST_AW - WIN_AW;
  localparam logic [WIN_TAG_W-1:0] WIN_TAG = WIN_TAG_W'(2);

  logic       req_q;
  logic       irq_en;
  logic [1:0] stat_idx;
  logic [7:0] port;
  logic       start, wr_ev, rd_ev;
  logic [7:0] stat_val;
  logic       unused_wdata;

  assign unused_wdata = ^io_wdata;
  assign port  = io_addr[7:0];
  assign start = io_req && !req_q;
  assign wr_ev = start && !io_rd;
  assign rd_ev = start && io_rd;

  always_comb begin
    case (stat_idx)
      2'd0:    stat_val = 8'hC7;
      2'd1:    stat_val = 8'h55;
      default: stat_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      sub_rst  <= 1'b1;
      irq_en   <= 1'b0;
      irq_req  <= 1'b0;
      bank_sel <= 1'b0;
      stat_idx <= 2'd0;
      io_rdata <= '1;
    end else begin
      req_q <= io_req;
      if (wr_ev) begin
        case (port)
          P_RST_ON:  sub_rst  <= 1'b1;
          P_RST_OFF: sub_rst  <= 1'b0;
          P_IRQ_OFF: irq_en   <= 1'b0;
          P_IRQ_ON:  irq_en   <= 1'b1;
          P_BANK0:   bank_sel <= 1'b0;
          P_BANK1:   bank_sel <= 1'b1;
          default: ;
        endcase
      end
      if ((wr_ev && port == P_IRQ_OFF) || irq_ack)
        irq_req <= 1'b0;
      else if (vblank && irq_en)
        irq_req <= 1'b1;
      if (rd_ev) begin
        if (port == P_STATUS) begin
          io_rdata <= DW'(stat_val);
          stat_idx <= (stat_idx == 2'd2) ? 2'd0 : stat_idx + 2'd1;
        end else begin
          io_rdata <= '1;
        end
      end
    end
  end

  assign rom_cs   = host_addr[HOST_AW-1:WIN_AW] == WIN_TAG;
  assign rom_addr = {bank_sel, host_addr[WIN_AW-1:0]};

  AST_RST_ON:   assert property (@(posedge clk) disable iff (!rst_n) wr_ev && port == P_RST_ON |=> sub_rst);   // R1
  AST_RST_OFF:  assert property (@(posedge clk) disable iff (!rst_n) wr_ev && port == P_RST_OFF |=> !sub_rst); // R2
  AST_IRQ_KILL: assert property (@(posedge clk) disable iff (!rst_n) wr_ev && port == P_IRQ_OFF |=> !irq_req && !irq_en); // R3
  AST_IRQ_SRC:  assert property (@(posedge clk) disable iff (!rst_n) !irq_req ##1 irq_req |-> $past(irq_en) && $past(vblank)); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_req && !irq_ack && !(wr_ev && port == P_IRQ_OFF) |=> irq_req); // R4
  AST_BANK:     assert property (@(posedge clk) disable iff (!rst_n) wr_ev && port == P_BANK1 |=> bank_sel); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(rd_ev && port == P_STATUS) |=> $stable(stat_idx)); // R8
  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) stat_idx != 2'd3); // R7
  AST_RD_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !rd_ev |=> $stable(io_rdata)); // R7
endmodule

// File: tb/sys_ctl_port_tb_top.sv
module sys_ctl_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_req = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        vblank = 0, irq_ack = 0;
  logic [15:0] host_addr = 0;
  logic        sub_rst, irq_req, bank_sel, rom_cs;
  logic [14:0] rom_addr;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2 clk = ~clk;

  sys_ctl_port dut_i (.clk(clk), .rst_n(rst_n), .io_req(io_req), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .vblank(vblank),
    .irq_ack(irq_ack), .host_addr(host_addr), .sub_rst(sub_rst), .irq_req(irq_req),
    .bank_sel(bank_sel), .rom_cs(rom_cs), .rom_addr(rom_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_req = 1; io_rd = 0; io_addr = a; io_wdata = d;
    @(negedge clk); io_req = 0;
    @(negedge clk);
  endtask

  task automatic io_read(input logic [15:0] a, input int hold, output logic [7:0] v);
    @(negedge clk); io_req = 1; io_rd = 1; io_addr = a;
    repeat (hold) @(negedge clk);
    v = io_rdata; io_req = 0;
    @(negedge clk);
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1; @(negedge clk); vblank = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 sub_rst", sub_rst, 1);
    chk("R11 irq_req", irq_req, 0);
    chk("R11 bank", bank_sel, 0);
    chk("R11 rdata", io_rdata, 8'hFF);
    pulse_vb();
    chk("R11 irq disabled after reset", irq_req, 0);
    io_read(16'h0000, 1, v);
    chk("R11 first status", v, 8'hC7);
  endtask

  task automatic t_subcpu();
    io_write(16'h0001, 8'h00); chk("R2 release", sub_rst, 0);
    io_write(16'h0000, 8'h00); chk("R1 assert d=00", sub_rst, 1);
    io_write(16'h0001, 8'hA5); chk("R2 release d=A5", sub_rst, 0);
    io_write(16'h0000, 8'hFF); chk("R1 assert d=FF", sub_rst, 1);
    io_write(16'h0001, 8'h3C); chk("R2 release again", sub_rst, 0);
  endtask

  task automatic t_irq();
    io_write(16'h0007, 8'h00);
    chk("R3 enable no pending", irq_req, 0);
    pulse_vb(); chk("R4 set", irq_req, 1);
    repeat (5) @(negedge clk); chk("R4 held", irq_req, 1);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R4 ack clears", irq_req, 0);
    pulse_vb(); chk("R4 set again", irq_req, 1);
    io_write(16'h0006, 8'hFF); chk("R3 disable clears", irq_req, 0);
    pulse_vb(); chk("R4 ignored while disabled", irq_req, 0);
    io_write(16'h0007, 8'h00);
    @(negedge clk); vblank = 1; irq_ack = 1; @(negedge clk); vblank = 0; irq_ack = 0;
    chk("R4 clear wins", irq_req, 0);
    chk("R3 sub_rst untouched", sub_rst, 0);
  endtask

  task automatic t_bank_rom();
    host_addr = 16'h8123; #1;
    chk("R6 cs bank0", rom_cs, 1); chk("R6 addr bank0", rom_addr, 15'h0123);
    io_write(16'h0009, 8'h00); chk("R5 bank1", bank_sel, 1);
    host_addr = 16'hBFFF; #1;
    chk("R6 cs top", rom_cs, 1); chk("R6 addr bank1", rom_addr, 15'h7FFF);
    host_addr = 16'h7FFF; #1; chk("R6 below window", rom_cs, 0);
    host_addr = 16'hC000; #1; chk("R6 above window", rom_cs, 0);
    io_write(16'h0008, 8'hFF); chk("R5 bank0", bank_sel, 0);
    host_addr = 16'hA000; #1; chk("R6 addr bank0 again", rom_addr, 15'h2000);
  endtask

  task automatic t_status();
    logic [7:0] v;
    io_read(16'h0000, 1, v); chk("R7 step 1", v, 8'h55);
    io_read(16'h0000, 4, v); chk("R8 held strobe", v, 8'h00);
    io_read(16'h0003, 1, v); chk("R8 other port FF", v, 8'hFF);
    io_read(16'h00F0, 3, v); chk("R8 other port FF held", v, 8'hFF);
    io_read(16'h0000, 1, v); chk("R7 wrap", v, 8'hC7);
    io_read(16'h0000, 1, v); chk("R7 after wrap", v, 8'h55);
    repeat (3) @(negedge clk); chk("R7 rdata holds", io_rdata, 8'h55);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    io_write(16'h0007, 8'h00);
    io_write(16'h0009, 8'h00);
    for (int p = 2; p <= 15; p++)
      if (p < 6 || p > 9) io_write(16'(p), 8'(p * 17));
    chk("R9 sub_rst", sub_rst, 0);
    chk("R9 bank", bank_sel, 1);
    chk("R9 rdata", io_rdata, 8'h55);
    pulse_vb(); chk("R9 irq still enabled", irq_req, 1);
    io_read(16'h0000, 1, v); chk("R9 status not moved", v, 8'h00);
    io_write(16'h0006, 8'h00);
  endtask

  task automatic t_alias();
    logic [7:0] v;
    io_write(16'h0100, 8'h12); chk("R10 alias of 0x00", sub_rst, 1);
    io_write(16'hFF08, 8'h00); chk("R10 alias of 0x08", bank_sel, 0);
    io_read(16'h5A00, 1, v); chk("R10 alias status read", v, 8'hC7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_subcpu();
    t_irq();
    t_bank_rom();
    t_status();
    t_ignored();
    t_alias();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule